// File: doc/BRIEF.md
# Serial DAC write controller

This block sits on the host side of a 12-bit serial digital-to-analog converter. It accepts a code through a valid/ready handshake and drives the converter's serial port: an active-low select, a serial clock that idles high, a data line and an active-low load strobe. An optional active-low clear output is pulsed when a separate clear request is raised. The word goes out MSB first on rising clock edges. The load strobe stays high during the whole transfer, so the converter output never takes a partial code. After the last bit the controller pulses the load strobe and then releases the select.

Every interface minimum is a parameter given in nanoseconds. The block turns each one into whole system-clock cycles, rounding up. Each phase of the sequence then lasts the larger of the minimums that apply to it. Elaboration stops if the resulting serial clock would run faster than the allowed maximum. When a clear request and a write arrive together, the clear is served first.

Top module: `sdac_wr_ctrl`

## Requirements
- R1: Each accepted code is shifted out as exactly DATA_W (12) bits, most significant bit first, one bit per rising edge of `sdac_sck`, before the load pulse for that code.
- R2: Every high phase and every low phase of `sdac_sck` inside a frame lasts at least 30 ns.
- R3: `sdac_sdo` does not change during the 15 ns before any rising edge of `sdac_sck`, nor during the 15 ns after it.
- R4: `sdac_csn` falls at least 30 ns before the first rising edge of a frame and rises no earlier than 20 ns after the last rising edge.
- R5: `sdac_ldn` stays high while bits are being shifted. Its low pulse lasts at least 20 ns and starts at least 15 ns after the final rising edge. `sdac_sck` does not fall again until at least 10 ns after `sdac_ldn` returns high.
- R6: A served clear request drives `sdac_clrn` low for at least 30 ns, with select, clock and load all high during the pulse.
- R7: A clear request has priority. While `clr_req` is high, `wr_ready` is low. If clear and write are requested together, the clear pulse begins before the select falls.
- R8: In idle, `sdac_csn`, `sdac_sck`, `sdac_ldn` and `sdac_clrn` are high and `wr_ready` is high. `wr_ready` is low for the whole of a frame or a clear pulse.
- R9: The serial clock period is at least 50 ns (20 MHz maximum). Parameter values that would break this stop elaboration.
- R10: Each minimum is converted to cycles as ceil(ns*1000/CLK_PS). The sck low phase lasts exactly max(low time, data setup) and the high phase exactly max(high time, data hold). At CLK_PS = 8000 that is 4 cycles each.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_valid | input | 1 | Write request, code on `wr_code` |
| wr_code | input | DATA_W | Code to send to the converter |
| wr_ready | output | 1 | High when a write is accepted this cycle |
| clr_req | input | 1 | Clear request (ignored when HAS_CLR = 0) |
| sdac_csn | output | 1 | Converter select, active low |
| sdac_sck | output | 1 | Serial clock, idles high |
| sdac_sdo | output | 1 | Serial data to the converter |
| sdac_ldn | output | 1 | Load strobe, active low |
| sdac_clrn | output | 1 | Clear strobe, active low |

## Verification
The bench builds the block with its default timing minimums, a 12-bit word, the clear path present and CLK_PS = 8000. These values give low and high phases of 4 cycles, a 2-cycle data and load setup and a 3-cycle load pulse, so every phase length lands on a distinct, countable number of cycles. Codes with all ones, all zeros, alternating bits and single set bits show a wrong bit order or a lost bit. A clear issued alone, and one issued together with a write, show the priority ordering and the clear pulse width.

// File: rtl/sdac_pkg.sv
package sdac_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_CSS,
      ST_LO,
      ST_HI,
      ST_LDSU,
      ST_LDP,
      ST_LDH,
      ST_CLR
   } sdac_state_e;

   // whole system-clock cycles covering a time in ns, rounded up, at least one
   function automatic int sdac_cyc(input int t_ns, input int clk_ps);
      int c;
      c = (t_ns * 1000 + clk_ps - 1) / clk_ps;
      return (c < 1) ? 1 : c;
   endfunction

   function automatic int sdac_max(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/sdac_tmr.sv
module sdac_tmr #(
   parameter int TW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [TW-1:0] val,
   output logic          done
);

   logic [TW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt <= '0;
      else if (load)       cnt <= val;
      else if (cnt != '0)  cnt <= cnt - 1'b1;
   end

   assign done = (cnt == '0);

endmodule

// File: rtl/sdac_shreg.sv
module sdac_shreg #(
   parameter int W = 12
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] din,
   input  logic         shift,
   output logic         msb
);

   logic [W-1:0] q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      q <= '0;
      else if (load)   q <= din;
      else if (shift)  q <= {q[W-2:0], 1'b0};
   end

   assign msb = q[W-1];

endmodule

// File: rtl/sdac_wr_ctrl.sv
module sdac_wr_ctrl
   import sdac_pkg::*;
#(
   parameter int DATA_W        = 12,
   parameter bit HAS_CLR       = 1'b1,
   parameter int CLK_PS        = 8000,
   parameter int T_SCKH_NS     = 30,
   parameter int T_SCKL_NS     = 30,
   parameter int T_DS_NS       = 15,
   parameter int T_DH_NS       = 15,
   parameter int T_CSS_NS      = 30,
   parameter int T_CSH_NS      = 20,
   parameter int T_LDW_NS      = 20,
   parameter int T_LD1_NS      = 15,
   parameter int T_LD2_NS      = 10,
   parameter int T_CLRW_NS     = 30,
   parameter int F_SCK_MAX_KHZ = 20000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_valid,
   input  logic [DATA_W-1:0] wr_code,
   output logic              wr_ready,
   input  logic              clr_req,
   output logic              sdac_csn,
   output logic              sdac_sck,
   output logic              sdac_sdo,
   output logic              sdac_ldn,
   output logic              sdac_clrn
);

   // ---- derived phase lengths (R10) ----
   localparam int D_CSS = sdac_cyc(T_CSS_NS, CLK_PS);
   localparam int D_LO  = sdac_max(sdac_cyc(T_SCKL_NS, CLK_PS), sdac_cyc(T_DS_NS, CLK_PS));
   localparam int D_HI  = sdac_max(sdac_cyc(T_SCKH_NS, CLK_PS), sdac_cyc(T_DH_NS, CLK_PS));
   localparam int D_LD1 = sdac_cyc(T_LD1_NS, CLK_PS);
   localparam int D_LDW = sdac_cyc(T_LDW_NS, CLK_PS);
   localparam int D_LDH = sdac_max(sdac_cyc(T_LD2_NS, CLK_PS),
                                   sdac_cyc(T_CSH_NS, CLK_PS) - D_HI - D_LD1 - D_LDW);
   localparam int D_CLR = sdac_cyc(T_CLRW_NS, CLK_PS);
   localparam int D_MAX = sdac_max(sdac_max(sdac_max(D_CSS, D_LO), sdac_max(D_HI, D_LD1)),
                                   sdac_max(sdac_max(D_LDW, D_LDH), D_CLR));
   localparam int TW     = $clog2(D_MAX + 1);
   localparam int BW     = $clog2(DATA_W);
   localparam int SCK_PS = (D_LO + D_HI) * CLK_PS;
   localparam int MIN_PS = 1000000000 / F_SCK_MAX_KHZ;

   // ---- elaboration checks (R9) ----
   generate
      if (SCK_PS < MIN_PS) begin : g_bad_sck
         $error("serial clock period %0d ps below limit %0d ps", SCK_PS, MIN_PS);
      end
      if (DATA_W < 2) begin : g_bad_w
         $error("DATA_W must be at least 2");
      end
      if (CLK_PS < 1) begin : g_bad_clk
         $error("CLK_PS must be positive");
      end
   endgenerate

   // ---- optional clear path ----
   logic clr_en;
   generate
      if (HAS_CLR) begin : g_clr
         assign clr_en = clr_req;
      end else begin : g_noclr
         assign clr_en = 1'b0;
      end
   endgenerate

   sdac_state_e   st, nxt;
   logic          tld, tdone, sh_ld, sh_go;
   logic [TW-1:0] tval;
   logic [BW-1:0] bitc;
   logic          last_bit;

   assign last_bit = (bitc == BW'(DATA_W - 1));

   sdac_tmr #(.TW(TW)) u_tmr (
      .clk  (clk),
      .rst_n(rst_n),
      .load (tld),
      .val  (tval),
      .done (tdone)
   );

   sdac_shreg #(.W(DATA_W)) u_shr (
      .clk  (clk),
      .rst_n(rst_n),
      .load (sh_ld),
      .din  (wr_code),
      .shift(sh_go),
      .msb  (sdac_sdo)
   );

   always_comb begin
      nxt   = st;
      tld   = 1'b0;
      tval  = '0;
      sh_ld = 1'b0;
      sh_go = 1'b0;
      unique case (st)
         ST_IDLE: begin
            if (clr_en) begin                       // R7 clear wins
               nxt = ST_CLR;  tld = 1'b1; tval = TW'(D_CLR - 1);
            end else if (wr_valid) begin
               nxt = ST_CSS;  tld = 1'b1; tval = TW'(D_CSS - 1); sh_ld = 1'b1;
            end
         end
         ST_CSS: if (tdone) begin
            nxt = ST_LO;   tld = 1'b1; tval = TW'(D_LO - 1);
         end
         ST_LO: if (tdone) begin
            nxt = ST_HI;   tld = 1'b1; tval = TW'(D_HI - 1);
         end
         ST_HI: if (tdone) begin
            if (last_bit) begin
               nxt = ST_LDSU; tld = 1'b1; tval = TW'(D_LD1 - 1);
            end else begin
               nxt = ST_LO;   tld = 1'b1; tval = TW'(D_LO - 1); sh_go = 1'b1;
            end
         end
         ST_LDSU: if (tdone) begin
            nxt = ST_LDP;  tld = 1'b1; tval = TW'(D_LDW - 1);
         end
         ST_LDP: if (tdone) begin
            nxt = ST_LDH;  tld = 1'b1; tval = TW'(D_LDH - 1);
         end
         ST_LDH:  if (tdone) nxt = ST_IDLE;
         ST_CLR:  if (tdone) nxt = ST_IDLE;
         default: nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st <= ST_IDLE;
      else        st <= nxt;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      bitc <= '0;
      else if (sh_ld)  bitc <= '0;
      else if (sh_go)  bitc <= bitc + 1'b1;
   end

   assign wr_ready  = (st == ST_IDLE) && !clr_en;
   assign sdac_csn  = (st == ST_IDLE) || (st == ST_CLR);
   assign sdac_sck  = (st != ST_LO);
   assign sdac_ldn  = (st != ST_LDP);
   assign sdac_clrn = (st != ST_CLR);

   // ---- assertions ----
   a_r5_ld_high_while_shift: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sdac_sck) |-> (sdac_ldn && !sdac_csn));

   a_r3_data_stable_high: assert property (@(posedge clk) disable iff (!rst_n)
      (sdac_sck && $past(sdac_sck) && !sdac_csn && !$past(sdac_csn)) |-> $stable(sdac_sdo));

   a_r4_release_clock_high: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sdac_csn) |-> (sdac_sck && sdac_ldn && $past(sdac_ldn)));

   a_r6_clear_alone: assert property (@(posedge clk) disable iff (!rst_n)
      !sdac_clrn |-> (sdac_csn && sdac_sck && sdac_ldn));

   a_r8_ready_only_idle: assert property (@(posedge clk) disable iff (!rst_n)
      wr_ready |-> (sdac_csn && sdac_clrn && sdac_ldn && sdac_sck));

   generate
      if (HAS_CLR) begin : g_clr_chk
         a_r7_clear_first: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(sdac_csn) |-> !$past(clr_req));
      end
   endgenerate

endmodule

// File: tb/sdac_wr_ctrl_tb.sv
module sdac_wr_ctrl_tb;

   localparam int W      = 12;
   localparam int CLK_PS = 8000;

   function automatic int up_cyc(input int ns);
      return (ns * 1000 + CLK_PS - 1) / CLK_PS;
   endfunction

   // expected minimums in cycles, from the requirements
   localparam int N_CH   = up_cyc(30);
   localparam int N_CL   = up_cyc(30);
   localparam int N_DS   = up_cyc(15);
   localparam int N_DH   = up_cyc(15);
   localparam int N_CSS  = up_cyc(30);
   localparam int N_CSH  = up_cyc(20);
   localparam int N_LDW  = up_cyc(20);
   localparam int N_LD1  = up_cyc(15);
   localparam int N_LD2  = up_cyc(10);
   localparam int N_CLRW = up_cyc(30);
   localparam int N_PER  = up_cyc(50);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic wr_valid = 1'b0;
   logic [W-1:0] wr_code = '0;
   logic clr_req = 1'b0;
   logic wr_ready, sdac_csn, sdac_sck, sdac_sdo, sdac_ldn, sdac_clrn;

   always #4ns clk = ~clk;   // 125 MHz

   sdac_wr_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_code(wr_code),
      .wr_ready(wr_ready), .clr_req(clr_req), .sdac_csn(sdac_csn),
      .sdac_sck(sdac_sck), .sdac_sdo(sdac_sdo), .sdac_ldn(sdac_ldn),
      .sdac_clrn(sdac_clrn)
   );

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", req, act, exp);
      end
   endtask

   logic [W-1:0] exp_q[$];

   // ---- monitor ----
   int cyc = 0;
   logic p_csn = 1'b1, p_sck = 1'b1, p_sdo = 1'b0, p_ldn = 1'b1, p_clrn = 1'b1;
   int cs_fall_c = 0, rise_c = -100, fall_c = 0, sdo_c = -100;
   int ld_fall_c = 0, ld_rise_c = -100, clr_fall_c = 0, prev_rise_c = 0;
   int cs_fall_last = 0, clr_fall_last = 0;
   int nbits = 0;
   logic [W-1:0] word = '0;

   always @(negedge clk) begin
      if (rst_n) begin
         cyc++;
         if (!sdac_csn) chk(!wr_ready, "R8 ready low in frame", wr_ready, 0);
         if (p_csn && !sdac_csn) begin
            cs_fall_c = cyc; cs_fall_last = cyc; nbits = 0; word = '0;
         end
         if (!sdac_csn && (sdac_sdo != p_sdo)) begin
            chk(cyc - rise_c >= N_DH, "R3 hold", cyc - rise_c, N_DH);
            sdo_c = cyc;
         end
         if (p_sck && !sdac_sck) begin
            chk(sdac_ldn && !sdac_csn, "R5 load high while shifting", sdac_ldn, 1);
            chk(cyc - ld_rise_c >= N_LD2, "R5 load to clock", cyc - ld_rise_c, N_LD2);
            if (nbits > 0) begin
               chk(cyc - rise_c >= N_CH, "R2 high width", cyc - rise_c, N_CH);
               chk(cyc - rise_c == 4, "R10 high phase exact", cyc - rise_c, 4);
            end
            fall_c = cyc;
         end
         if (!p_sck && sdac_sck) begin
            chk(cyc - fall_c >= N_CL, "R2 low width", cyc - fall_c, N_CL);
            chk(cyc - fall_c == 4, "R10 low phase exact", cyc - fall_c, 4);
            chk(cyc - sdo_c >= N_DS, "R3 setup", cyc - sdo_c, N_DS);
            if (nbits == 0)
               chk(cyc - cs_fall_c >= N_CSS, "R4 select setup", cyc - cs_fall_c, N_CSS);
            else
               chk(cyc - prev_rise_c >= N_PER, "R9 sck period", cyc - prev_rise_c, N_PER);
            word = {word[W-2:0], sdac_sdo};
            nbits++;
            rise_c = cyc; prev_rise_c = cyc;
         end
         if (p_ldn && !sdac_ldn) begin
            chk(nbits == W, "R1 bit count", nbits, W);
            chk(cyc - rise_c >= N_LD1, "R5 load setup", cyc - rise_c, N_LD1);
            ld_fall_c = cyc;
         end
         if (!p_ldn && sdac_ldn) begin
            chk(cyc - ld_fall_c >= N_LDW, "R5 load width", cyc - ld_fall_c, N_LDW);
            if (exp_q.size() == 0) chk(1'b0, "R1 unexpected load", word, 0);
            else begin
               logic [W-1:0] e;
               e = exp_q.pop_front();
               chk(word == e, "R1 word", word, e);
            end
            ld_rise_c = cyc;
         end
         if (!p_csn && sdac_csn)
            chk(cyc - rise_c >= N_CSH, "R4 select hold", cyc - rise_c, N_CSH);
         if (p_clrn && !sdac_clrn) begin
            clr_fall_c = cyc; clr_fall_last = cyc;
         end
         if (!sdac_clrn)
            chk(sdac_csn && sdac_sck && sdac_ldn, "R6 clear alone", sdac_csn, 1);
         if (!p_clrn && sdac_clrn)
            chk(cyc - clr_fall_c >= N_CLRW, "R6 clear width", cyc - clr_fall_c, N_CLRW);
      end
      p_csn = sdac_csn; p_sck = sdac_sck; p_sdo = sdac_sdo;
      p_ldn = sdac_ldn; p_clrn = sdac_clrn;
   end

   // ---- driver ----
   task automatic send(input logic [W-1:0] code);
      bit acc;
      @(negedge clk);
      wr_valid = 1'b1; wr_code = code;
      exp_q.push_back(code);
      do begin
         #1;
         acc = wr_ready;
         @(negedge clk);
      end while (!acc);
      wr_valid = 1'b0;
      #1;
      chk(!wr_ready, "R8 ready drops after accept", wr_ready, 0);
   endtask

   task automatic pulse_clear();
      @(negedge clk);
      clr_req = 1'b1;
      #1;
      chk(!wr_ready, "R7 ready low on clear request", wr_ready, 0);
      @(negedge clk);
      clr_req = 1'b0;
   endtask

   task automatic wait_idle();
      @(negedge clk);
      while (!(wr_ready && sdac_csn && sdac_clrn)) @(negedge clk);
   endtask

   task automatic check_idle(input string tag);
      chk(sdac_csn && sdac_sck && sdac_ldn && sdac_clrn && wr_ready, tag,
          {sdac_csn, sdac_sck, sdac_ldn, sdac_clrn, wr_ready}, 5'b11111);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check_idle("R8 reset levels");
      rst_n = 1'b1;
      @(negedge clk);
      check_idle("R8 idle after reset");

      send(12'hFFF);  wait_idle(); check_idle("R8 idle after frame");
      send(12'h000);  wait_idle();
      send(12'hA5A);  wait_idle();
      send(12'h5A5);  wait_idle();
      send(12'h800);  wait_idle();
      send(12'h001);  wait_idle();
      send(12'h123);  send(12'hFED);  wait_idle();

      pulse_clear(); wait_idle(); check_idle("R6 idle after clear");

      fork
         pulse_clear();
         send(12'h3C7);
      join
      wait_idle();
      chk(clr_fall_last < cs_fall_last, "R7 clear before frame", clr_fall_last, cs_fall_last);

      for (int i = 0; i < 4; i++) begin
         send(W'(12'h111 * (i + 1)));
         wait_idle();
      end

      repeat (5) @(negedge clk);
      chk(exp_q.size() == 0, "R1 all words loaded", exp_q.size(), 0);
      if (!finished) begin
         finished = 1'b1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         checks++; errors++;
         $display("FAIL watchdog actual 1 expected 0");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule